// File: doc/BRIEF.md
# Bus Borrowing Arbiter and Decoder

This block is master-side glue logic. It lets a master computer borrow the memory of a second computer, the slave, while the master is not busy producing its video display. A one-bit machine-state flag records whether the master is generating video or running its control program. The master sets and clears this flag by writing to two decoded I/O command ports.

While the flag shows the control program, the block requests the slave's bus. Once the slave acknowledges, the block enables the address buffers that drive the slave memory. Master memory reads with A15 high then open the read-data buffer toward the slave, so the slave RAM appears above 32K. During those reads the master's own RAM chip select is forced off. When the master returns to video, the request is dropped at once and the slave program resumes.

All control strobes are active-low. The slave acknowledge passes through a synchronizer whose depth is a parameter. Every output is a flop.

Top module: `bus_borrow_ctl`

## Requirements
- R1: After reset, the machine state is video, `slave_req_n` is 1, `addr_buf_en_n` is 1, `data_buf_en_n` is 1 and `local_cs_off` is 0.
- R2: A video-command write sets the machine state to video. A video-command write is `io_req_n`=0, `io_wr_n`=0 and `video_sel`=1 sampled at a clock edge. At that same edge, `slave_req_n` goes to 1, `addr_buf_en_n` and `data_buf_en_n` go to 1, and `local_cs_off` goes to 0.
- R3: A run-command write sets the machine state to compute. A run-command write is `io_req_n`=0, `io_wr_n`=0 and `run_sel`=1, with `video_sel`=0. At that edge, `slave_req_n` goes to 0.
- R4: When `video_sel` and `run_sel` are both 1 during a qualified I/O write, the video command wins.
- R5: The machine state does not change when `io_req_n`=1, when `io_wr_n`=1, or when neither select is 1.
- R6: `addr_buf_en_n` goes to 0 at the (SYNC_STAGES+1)-th clock edge that samples `slave_ack_n`=0 while the request is held. It is only ever 0 while `slave_req_n` is 0.
- R7: `data_buf_en_n`=0 and `local_cs_off`=1 are registered at an edge that samples `mem_req_n`=0, `mem_rd_n`=0 and `addr_a15`=1 while the address buffers are granted. If `addr_a15`=0 or `mem_rd_n`=1 at that edge, the outputs return to `data_buf_en_n`=1 and `local_cs_off`=0.
- R8: Until the acknowledge has been synchronized, an upper-half read leaves `data_buf_en_n` at 1 and `local_cs_off` at 0, even with the request asserted.
- R9: After the request has been released, a new grant needs two things. The synchronized acknowledge must first be seen released (`slave_ack_n`=1), and then be seen asserted again. A stale acknowledge left over from the previous grant does not enable the address buffers.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_req_n | input | 1 | Master I/O request strobe, active low |
| io_wr_n | input | 1 | Master write strobe, active low |
| video_sel | input | 1 | Decoded select of the video command port |
| run_sel | input | 1 | Decoded select of the run command port |
| mem_req_n | input | 1 | Master memory request strobe, active low |
| mem_rd_n | input | 1 | Master read strobe, active low |
| addr_a15 | input | 1 | Master address bit 15 |
| slave_ack_n | input | 1 | Slave bus acknowledge, active low |
| slave_req_n | output | 1 | Bus request to the slave, active low |
| addr_buf_en_n | output | 1 | Address buffer enable, active low |
| data_buf_en_n | output | 1 | Read-data buffer enable, active low |
| local_cs_off | output | 1 | Forces the master local RAM chip select inactive |

## Verification
Each result has a fixed due cycle:
- Command writes change `slave_req_n` at the edge that samples them.
- An upper-half read sets the data-buffer enable and the chip-select override at the edge that samples the read.
- The address enable follows an asserted acknowledge at edge SYNC_STAGES+1.

The bench drives inputs and samples outputs one time unit after a rising edge. It counts edges explicitly, so each check lands in its due cycle. For the acknowledge path it also checks one edge early, which proves the enable is not premature. The re-arm scenario counts the synchronizer edges in both directions of the acknowledge before expecting a grant.

// File: rtl/busborrow_pkg.sv
package busborrow_pkg;
  typedef enum logic {
    MS_VIDEO   = 1'b0,
    MS_COMPUTE = 1'b1
  } mstate_e;
endpackage

// File: rtl/bb_mode_track.sv
module bb_mode_track
  import busborrow_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    io_req_n,
  input  logic    io_wr_n,
  input  logic    video_sel,
  input  logic    run_sel,
  output mstate_e state_d,
  output mstate_e state_q
);
  logic io_write;
  logic go_video;
  logic go_run;

  assign io_write = !io_req_n && !io_wr_n;
  assign go_video = io_write && video_sel;
  assign go_run   = io_write && run_sel && !video_sel;

  always_comb begin
    state_d = state_q;
    if (go_video)    state_d = MS_VIDEO;
    else if (go_run) state_d = MS_COMPUTE;
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= MS_VIDEO;
    else     state_q <= state_d;
  end

  // R2
  video_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (!io_req_n && !io_wr_n && video_sel) |=> (state_q == MS_VIDEO));

  // R3
  run_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (!io_req_n && !io_wr_n && run_sel && !video_sel) |=> (state_q == MS_COMPUTE));

  // R5
  no_cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (io_req_n || io_wr_n || (!video_sel && !run_sel)) |=> $stable(state_q));
endmodule

// File: rtl/bb_ack_sync.sv
module bb_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ack_n,
  output logic acked
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  generate
    if (STAGES < 2) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= ack_n;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= {chain_q[LAST-1:0], ack_n};
      end
    end
  endgenerate

  assign acked = !chain_q[LAST];
endmodule

// File: rtl/bb_path_ctrl.sv
module bb_path_ctrl
  import busborrow_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  mstate_e state_d,
  input  logic    acked,
  input  logic    mem_req_n,
  input  logic    mem_rd_n,
  input  logic    addr_a15,
  output logic    slave_req_n,
  output logic    addr_buf_en_n,
  output logic    data_buf_en_n,
  output logic    local_cs_off
);
  logic want_bus;
  logic armed_q;
  logic armed_d;
  logic grant_d;
  logic upper_rd;

  assign want_bus = (state_d == MS_COMPUTE);
  assign upper_rd = !mem_req_n && !mem_rd_n && addr_a15;
  assign grant_d  = want_bus && !slave_req_n && armed_q && acked;

  // Re-arm only after the synchronized acknowledge has gone away.
  always_comb begin
    if (!acked)         armed_d = 1'b1;
    else if (!want_bus) armed_d = 1'b0;
    else                armed_d = armed_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q       <= 1'b1;
      slave_req_n   <= 1'b1;
      addr_buf_en_n <= 1'b1;
      data_buf_en_n <= 1'b1;
      local_cs_off  <= 1'b0;
    end else begin
      armed_q       <= armed_d;
      slave_req_n   <= !want_bus;
      addr_buf_en_n <= !grant_d;
      data_buf_en_n <= !(grant_d && upper_rd);
      local_cs_off  <= grant_d && upper_rd;
    end
  end

  // R6
  addr_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    !addr_buf_en_n |-> !slave_req_n);

  // R6
  addr_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(addr_buf_en_n) |-> $past(acked));

  // R7
  data_upper_rd_chk: assert property (@(posedge clk) disable iff (rst)
    !data_buf_en_n |-> $past(!mem_req_n && !mem_rd_n && addr_a15));

  // R7
  cs_off_with_data_chk: assert property (@(posedge clk) disable iff (rst)
    local_cs_off |-> (!data_buf_en_n && !addr_buf_en_n));

  // R9
  rearm_chk: assert property (@(posedge clk) disable iff (rst)
    (!armed_q && acked) |=> addr_buf_en_n);
endmodule

// File: rtl/bus_borrow_ctl.sv
module bus_borrow_ctl
  import busborrow_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic io_req_n,
  input  logic io_wr_n,
  input  logic video_sel,
  input  logic run_sel,
  input  logic mem_req_n,
  input  logic mem_rd_n,
  input  logic addr_a15,
  input  logic slave_ack_n,
  output logic slave_req_n,
  output logic addr_buf_en_n,
  output logic data_buf_en_n,
  output logic local_cs_off
);
  mstate_e state_d;
  mstate_e state_q;
  logic    acked;

  bb_mode_track u_mode (
    .clk       (clk),
    .rst       (rst),
    .io_req_n  (io_req_n),
    .io_wr_n   (io_wr_n),
    .video_sel (video_sel),
    .run_sel   (run_sel),
    .state_d   (state_d),
    .state_q   (state_q)
  );

  bb_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .ack_n (slave_ack_n),
    .acked (acked)
  );

  bb_path_ctrl u_path (
    .clk           (clk),
    .rst           (rst),
    .state_d       (state_d),
    .acked         (acked),
    .mem_req_n     (mem_req_n),
    .mem_rd_n      (mem_rd_n),
    .addr_a15      (addr_a15),
    .slave_req_n   (slave_req_n),
    .addr_buf_en_n (addr_buf_en_n),
    .data_buf_en_n (data_buf_en_n),
    .local_cs_off  (local_cs_off)
  );

  // R1
  reset_video_chk: assert property (@(posedge clk)
    $past(rst) |-> (state_q == MS_VIDEO && slave_req_n && !local_cs_off));
endmodule

// File: tb/bus_borrow_ctl_tb.sv
`timescale 1ns/1ps
module bus_borrow_ctl_tb_top;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic io_req_n = 1'b1, io_wr_n = 1'b1, video_sel = 1'b0, run_sel = 1'b0;
  logic mem_req_n = 1'b1, mem_rd_n = 1'b1, addr_a15 = 1'b0, slave_ack_n = 1'b1;
  logic slave_req_n, addr_buf_en_n, data_buf_en_n, local_cs_off;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bus_borrow_ctl #(.SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .rst(rst), .io_req_n(io_req_n), .io_wr_n(io_wr_n),
    .video_sel(video_sel), .run_sel(run_sel), .mem_req_n(mem_req_n),
    .mem_rd_n(mem_rd_n), .addr_a15(addr_a15), .slave_ack_n(slave_ack_n),
    .slave_req_n(slave_req_n), .addr_buf_en_n(addr_buf_en_n),
    .data_buf_en_n(data_buf_en_n), .local_cs_off(local_cs_off)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic io_write(input logic vs, input logic rs);
    io_req_n = 1'b0; io_wr_n = 1'b0; video_sel = vs; run_sel = rs;
    step(1);
    io_req_n = 1'b1; io_wr_n = 1'b1; video_sel = 1'b0; run_sel = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "slave_req_n", slave_req_n, 1'b1);
    chk("R1", "addr_buf_en_n", addr_buf_en_n, 1'b1);
    chk("R1", "data_buf_en_n", data_buf_en_n, 1'b1);
    chk("R1", "local_cs_off", local_cs_off, 1'b0);
  endtask

  task automatic t_request_no_ack();
    io_write(1'b0, 1'b1);
    chk("R3", "slave_req_n after run write", slave_req_n, 1'b0);
    mem_req_n = 1'b0; mem_rd_n = 1'b0; addr_a15 = 1'b1;
    step(1);
    chk("R8", "data_buf_en_n before ack", data_buf_en_n, 1'b1);
    chk("R8", "local_cs_off before ack", local_cs_off, 1'b0);
    mem_req_n = 1'b1; mem_rd_n = 1'b1; addr_a15 = 1'b0;
    step(1);
  endtask

  task automatic t_ack();
    slave_ack_n = 1'b0;
    step(SYNC);
    chk("R6", "addr_buf_en_n one edge early", addr_buf_en_n, 1'b1);
    step(1);
    chk("R6", "addr_buf_en_n at due edge", addr_buf_en_n, 1'b0);
  endtask

  task automatic t_read();
    mem_req_n = 1'b0; mem_rd_n = 1'b0; addr_a15 = 1'b1;
    step(1);
    chk("R7", "data_buf_en_n upper read", data_buf_en_n, 1'b0);
    chk("R7", "local_cs_off upper read", local_cs_off, 1'b1);
    addr_a15 = 1'b0;
    step(1);
    chk("R7", "data_buf_en_n lower read", data_buf_en_n, 1'b1);
    chk("R7", "local_cs_off lower read", local_cs_off, 1'b0);
    addr_a15 = 1'b1; mem_rd_n = 1'b1;
    step(1);
    chk("R7", "data_buf_en_n upper non-read", data_buf_en_n, 1'b1);
    mem_req_n = 1'b1; addr_a15 = 1'b0;
  endtask

  task automatic t_ignore();
    io_req_n = 1'b1; io_wr_n = 1'b0; video_sel = 1'b1;
    step(1);
    chk("R5", "slave_req_n without io_req", slave_req_n, 1'b0);
    io_req_n = 1'b0; io_wr_n = 1'b1;
    step(1);
    chk("R5", "slave_req_n without io_wr", slave_req_n, 1'b0);
    io_wr_n = 1'b0; video_sel = 1'b0;
    step(1);
    chk("R5", "slave_req_n without select", slave_req_n, 1'b0);
    chk("R5", "addr_buf_en_n kept", addr_buf_en_n, 1'b0);
    io_req_n = 1'b1; io_wr_n = 1'b1;
  endtask

  task automatic t_release();
    mem_req_n = 1'b0; mem_rd_n = 1'b0; addr_a15 = 1'b1;
    io_write(1'b1, 1'b0);
    chk("R2", "slave_req_n after video write", slave_req_n, 1'b1);
    chk("R2", "addr_buf_en_n after video write", addr_buf_en_n, 1'b1);
    chk("R2", "data_buf_en_n after video write", data_buf_en_n, 1'b1);
    chk("R2", "local_cs_off after video write", local_cs_off, 1'b0);
    mem_req_n = 1'b1; mem_rd_n = 1'b1; addr_a15 = 1'b0;
  endtask

  task automatic t_both();
    io_write(1'b0, 1'b1);
    chk("R3", "slave_req_n second run write", slave_req_n, 1'b0);
    io_write(1'b1, 1'b1);
    chk("R4", "slave_req_n both selects", slave_req_n, 1'b1);
  endtask

  task automatic t_rearm();
    io_write(1'b0, 1'b1);
    step(SYNC + 2);
    chk("R9", "addr_buf_en_n with stale ack", addr_buf_en_n, 1'b1);
    slave_ack_n = 1'b1;
    step(SYNC + 1);
    chk("R9", "addr_buf_en_n ack released", addr_buf_en_n, 1'b1);
    slave_ack_n = 1'b0;
    step(SYNC);
    chk("R9", "addr_buf_en_n re-ack early", addr_buf_en_n, 1'b1);
    step(1);
    chk("R9", "addr_buf_en_n re-granted", addr_buf_en_n, 1'b0);
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    t_reset();
    t_request_no_ack();
    t_ack();
    t_read();
    t_ignore();
    t_release();
    t_both();
    t_rearm();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    while (cycles < 5000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule